// File: doc/BRIEF.md
# Banked Flash Window Mapper

This block lets a processor with a 20-bit address space reach a 4 MB external database flash. The processor sees the flash through a 64 KB main window. A 6-bit bank register chooses which 64 KB slice of the flash lies behind that window. Software loads the register by writing to a discrete register select while the write strobe is low. The bank number comes from the low bits of the processor data bus.

A second, 2 KB window sits directly above the main window. It always reaches the first 2 KB of the bank that follows the current one. The following bank number comes from a 6-bit incrementer, so a record that runs past the end of a bank can be read on without any register write. The block drives the upper physical address bits, the active-low flash chip select and a flag for each window. The address decode and mapping are combinational from the processor address and the registered bank.

Top module: `dbwin_mapper`

## Requirements
- R1: After reset the bank register holds 0, so a main-window access at 0xC1234 maps to flash address 0x001234.
- R2: When `bank_sel_n` and `cpu_wr_n` are both low at a rising clock edge, the bank register takes `cpu_data[5:0]`. The new bank is used from that edge onward.
- R3: On a bank write, `cpu_data[15:6]` are ignored.
- R4: No bank load takes place when only one of `bank_sel_n` and `cpu_wr_n` is low.
- R5: A processor address in 0xC0000–0xCFFFF is in the main window and sets `hit_main`. During an access there, `flash_addr` = {bank, cpu_addr[15:0]}, with the bank in bits 21:16.
- R6: A processor address in 0xD0000–0xD07FF is in the crossover window and sets `hit_xover`. During an access there, `flash_addr` = {bank+1, 5'b0, cpu_addr[10:0]}.
- R7: The bank+1 sum wraps modulo 64, so from bank 63 the crossover window reaches bank 0.
- R8: `flash_cs_n` is low exactly when `cpu_strobe_n` is low and the address is in either window. It stays high for addresses outside both windows, for example 0xBFFFF and 0xD0800.
- R9: While no window access is under way, `flash_addr` holds the last value it had during a window access.
- R10: `hit_main` and `hit_xover` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 20 | Processor byte address |
| cpu_data | input | 16 | Processor write data |
| cpu_strobe_n | input | 1 | Active-low access strobe |
| cpu_wr_n | input | 1 | Active-low write strobe |
| bank_sel_n | input | 1 | Active-low select of the bank register |
| flash_addr | output | 22 | Physical flash address (bank in 21:16) |
| flash_cs_n | output | 1 | Active-low flash chip select |
| hit_main | output | 1 | Address lies in the main window |
| hit_xover | output | 1 | Address lies in the crossover window |

## Verification
The bank register is the main internal state. A wrong bank value shows up in `flash_addr[21:16]` on the very next window access, with no delay. A crossover access shows the same fault shifted by one, and a bank of 63 exposes a missing wrap at once. A stale or wrongly updated hold register appears only on the first access outside the windows, as a `flash_addr` that differs from the last mapped value. That check needs an in-window access followed by an out-of-window one.

// File: rtl/dbwin_pkg.sv
// Package: shared types for the banked flash window mapper.
// Assumes: the windows never overlap, so one window kind per address.
package dbwin_pkg;

    // Which window a processor address falls into
    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_MAIN  = 2'd1,
        WIN_XOVER = 2'd2
    } win_kind_t;

endpackage

// File: rtl/dbwin_bank_reg.sv
// Module: dbwin_bank_reg
// Holds the current bank number. It loads the low BANK_W data bits when the
// load strobe is high at a clock edge.
// Assumes: load is already qualified by select and write strobes.
module dbwin_bank_reg #(
    parameter int DATA_W = 16,
    parameter int BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [BANK_W-1:0] bank_q
);

    // Upper data bits deliberately discarded
    logic unused_hi;
    assign unused_hi = ^din[DATA_W-1:BANK_W];

    // Bank register: clear on reset, load low data bits on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load) begin
            bank_q <= din[BANK_W-1:0];
        end
    end

endmodule

// File: rtl/dbwin_decode.sv
// Module: dbwin_decode
// Decodes a processor address into main window, crossover window or none.
// Purely combinational.
// Assumes: both bases are aligned to their window sizes and do not overlap.
module dbwin_decode
    import dbwin_pkg::*;
#(
    parameter int                CPU_AW     = 20,
    parameter int                WIN_AW     = 16,
    parameter int                XOVER_AW   = 11,
    parameter logic [CPU_AW-1:0] MAIN_BASE  = 20'hC0000,
    parameter logic [CPU_AW-1:0] XOVER_BASE = 20'hD0000
) (
    input  logic [CPU_AW-1:0] addr,
    output win_kind_t         kind
);

    localparam int MTAG_W = CPU_AW - WIN_AW;
    localparam int XTAG_W = CPU_AW - XOVER_AW;
    localparam logic [MTAG_W-1:0] MAIN_TAG  = MAIN_BASE[CPU_AW-1:WIN_AW];
    localparam logic [XTAG_W-1:0] XOVER_TAG = XOVER_BASE[CPU_AW-1:XOVER_AW];

    logic in_main;
    logic in_xover;

    // Tag compare against each window base
    always_comb begin
        in_main  = (addr[CPU_AW-1:WIN_AW]   == MAIN_TAG);
        in_xover = (addr[CPU_AW-1:XOVER_AW] == XOVER_TAG);
    end

    // Priority-free encode; windows are disjoint by parameter choice
    always_comb begin
        if (in_main) begin
            kind = WIN_MAIN;
        end else if (in_xover) begin
            kind = WIN_XOVER;
        end else begin
            kind = WIN_NONE;
        end
    end

endmodule

// File: rtl/dbwin_addr_gen.sv
// Module: dbwin_addr_gen
// Forms the physical flash address from the window kind, the bank and the
// in-window offset. The crossover window uses bank+1 (modulo 2**BANK_W) and
// forces the offset bits above XOVER_AW to zero.
// Assumes: the caller ignores the output when kind is WIN_NONE.
module dbwin_addr_gen
    import dbwin_pkg::*;
#(
    parameter int BANK_W   = 6,
    parameter int WIN_AW   = 16,
    parameter int XOVER_AW = 11
) (
    input  win_kind_t                kind,
    input  logic [BANK_W-1:0]        bank,
    input  logic [WIN_AW-1:0]        offset,
    output logic [BANK_W+WIN_AW-1:0] phys
);

    logic [BANK_W-1:0] bank_next;
    logic [BANK_W-1:0] bank_eff;
    logic [WIN_AW-1:0] offs_eff;

    // Wrapping incrementer for the crossover bank
    always_comb begin
        bank_next = bank + BANK_W'(1);
    end

    // Bank selection by window kind
    always_comb begin
        bank_eff = (kind == WIN_XOVER) ? bank_next : bank;
    end

    // Offset bits: low ones pass, high ones cleared in the crossover window
    for (genvar b = 0; b < WIN_AW; b++) begin : g_offs
        if (b < XOVER_AW) begin : g_low
            assign offs_eff[b] = offset[b];
        end else begin : g_high
            assign offs_eff[b] = offset[b] & (kind != WIN_XOVER);
        end
    end

    // Concatenate into the physical address
    always_comb begin
        phys = {bank_eff, offs_eff};
    end

endmodule

// File: rtl/dbwin_mapper.sv
// Module: dbwin_mapper (top)
// Maps a 64 KB main window and a 2 KB crossover window of the processor
// space onto a banked flash. It drives the physical address, the active-low
// chip select and the window flags. Outside any access the physical address
// keeps its last mapped value.
// Assumes: the bank write and the window accesses come from the same clock
// domain as clk.
module dbwin_mapper
    import dbwin_pkg::*;
#(
    parameter int                CPU_AW     = 20,
    parameter int                DATA_W     = 16,
    parameter int                BANK_W     = 6,
    parameter int                WIN_AW     = 16,
    parameter int                XOVER_AW   = 11,
    parameter logic [CPU_AW-1:0] MAIN_BASE  = 20'hC0000,
    parameter logic [CPU_AW-1:0] XOVER_BASE = 20'hD0000,
    localparam int               PHYS_AW    = BANK_W + WIN_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_data,
    input  logic               cpu_strobe_n,
    input  logic               cpu_wr_n,
    input  logic               bank_sel_n,
    output logic [PHYS_AW-1:0] flash_addr,
    output logic               flash_cs_n,
    output logic               hit_main,
    output logic               hit_xover
);

    logic               bank_load;
    logic [BANK_W-1:0]  bank_q;
    win_kind_t          kind;
    logic [PHYS_AW-1:0] mapped;
    logic [PHYS_AW-1:0] held_q;
    logic               acc_hit;

    // Qualify the bank write: both select and write strobe low
    always_comb begin
        bank_load = !bank_sel_n && !cpu_wr_n;
    end

    dbwin_bank_reg #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W)
    ) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (bank_load),
        .din    (cpu_data),
        .bank_q (bank_q)
    );

    dbwin_decode #(
        .CPU_AW     (CPU_AW),
        .WIN_AW     (WIN_AW),
        .XOVER_AW   (XOVER_AW),
        .MAIN_BASE  (MAIN_BASE),
        .XOVER_BASE (XOVER_BASE)
    ) i_dec (
        .addr (cpu_addr),
        .kind (kind)
    );

    dbwin_addr_gen #(
        .BANK_W   (BANK_W),
        .WIN_AW   (WIN_AW),
        .XOVER_AW (XOVER_AW)
    ) i_agen (
        .kind   (kind),
        .bank   (bank_q),
        .offset (cpu_addr[WIN_AW-1:0]),
        .phys   (mapped)
    );

    // Access qualifier: strobe active and address inside a window
    always_comb begin
        acc_hit = !cpu_strobe_n && (kind != WIN_NONE);
    end

    // Hold register: remembers the last mapped address of a window access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (acc_hit) begin
            held_q <= mapped;
        end
    end

    // Output drive: live mapping during an access, held value otherwise
    always_comb begin
        flash_addr = acc_hit ? mapped : held_q;
        flash_cs_n = !acc_hit;
        hit_main   = (kind == WIN_MAIN);
        hit_xover  = (kind == WIN_XOVER);
    end

endmodule

// File: rtl/dbwin_mapper_chk.sv
// Module: dbwin_mapper_chk
// Property checker for dbwin_mapper, attached by bind below.
// Assumes: rst_n is low from time zero until the first clock edges.
module dbwin_mapper_chk #(
    parameter int CPU_AW = 20,
    parameter int DATA_W = 16,
    parameter int BANK_W = 6,
    parameter int PHYS_AW = 22,
    parameter int XOVER_AW = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CPU_AW-1:0]  cpu_addr,
    input logic [DATA_W-1:0]  cpu_data,
    input logic               cpu_strobe_n,
    input logic               cpu_wr_n,
    input logic               bank_sel_n,
    input logic [PHYS_AW-1:0] flash_addr,
    input logic               flash_cs_n,
    input logic               hit_main,
    input logic               hit_xover,
    input logic [BANK_W-1:0]  bank_q
);

    logic unused_addr;
    assign unused_addr = ^cpu_addr;

    AST_BANK_RESET: assert property (@(posedge clk)
        !rst_n |=> (bank_q == '0)); // R1

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_sel_n && !cpu_wr_n) |=> (bank_q == $past(cpu_data[BANK_W-1:0]))); // R2

    AST_NO_HALF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bank_sel_n && !cpu_wr_n) |=> $stable(bank_q)); // R4

    AST_MAIN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_main && !cpu_strobe_n) |-> (flash_addr[PHYS_AW-1:PHYS_AW-BANK_W] == bank_q)); // R5

    AST_XOVER_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_xover && !cpu_strobe_n) |->
        ((flash_addr[PHYS_AW-1:PHYS_AW-BANK_W] == BANK_W'(bank_q + 1'b1)) &&
         (flash_addr[PHYS_AW-BANK_W-1:XOVER_AW] == '0))); // R6

    AST_CS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_main && !hit_xover) |-> flash_cs_n); // R8

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && flash_cs_n) |-> $stable(flash_addr)); // R9

    AST_WIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_main && hit_xover)); // R10

endmodule

bind dbwin_mapper dbwin_mapper_chk #(
    .CPU_AW   (CPU_AW),
    .DATA_W   (DATA_W),
    .BANK_W   (BANK_W),
    .PHYS_AW  (PHYS_AW),
    .XOVER_AW (XOVER_AW)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_data     (cpu_data),
    .cpu_strobe_n (cpu_strobe_n),
    .cpu_wr_n     (cpu_wr_n),
    .bank_sel_n   (bank_sel_n),
    .flash_addr   (flash_addr),
    .flash_cs_n   (flash_cs_n),
    .hit_main     (hit_main),
    .hit_xover    (hit_xover),
    .bank_q       (bank_q)
);

// File: tb/test_dbwin_mapper.sv
// Directed bench for dbwin_mapper: one task per scenario, each checks itself.
module test_dbwin_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [15:0] cpu_data = '0;
    logic        cpu_strobe_n = 1'b1;
    logic        cpu_wr_n = 1'b1;
    logic        bank_sel_n = 1'b1;
    logic [21:0] flash_addr;
    logic        flash_cs_n;
    logic        hit_main;
    logic        hit_xover;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk; // 125 MHz

    dbwin_mapper i_dbwin_mapper (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr     (cpu_addr),
        .cpu_data     (cpu_data),
        .cpu_strobe_n (cpu_strobe_n),
        .cpu_wr_n     (cpu_wr_n),
        .bank_sel_n   (bank_sel_n),
        .flash_addr   (flash_addr),
        .flash_cs_n   (flash_cs_n),
        .hit_main     (hit_main),
        .hit_xover    (hit_xover)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Bank write: strobes low across one rising edge, then released
    task automatic bank_write(input logic [15:0] d, input logic sel_n, input logic wr_n);
        cpu_data   = d;
        bank_sel_n = sel_n;
        cpu_wr_n   = wr_n;
        @(posedge clk); #1;
        bank_sel_n = 1'b1;
        cpu_wr_n   = 1'b1;
    endtask

    // Access: drive, sample at the falling edge, then pass one rising edge
    task automatic access(input logic [19:0] a, input logic strobe_n);
        cpu_addr     = a;
        cpu_strobe_n = strobe_n;
        @(negedge clk);
    endtask

    task automatic finish_access();
        @(posedge clk); #1;
        cpu_strobe_n = 1'b1;
    endtask

    task automatic t_reset();
        access(20'hC1234, 1'b1);
        check("R8 idle cs_n", 32'(flash_cs_n), 32'h1);
        finish_access();
        access(20'hC1234, 1'b0);
        check("R1 reset bank", 32'(flash_addr), 32'h001234);
        check("R8 cs_n main", 32'(flash_cs_n), 32'h0);
        finish_access();
    endtask

    task automatic t_load();
        bank_write(16'h0015, 1'b0, 1'b0);
        access(20'hC0000, 1'b0);
        check("R2 bank load", 32'(flash_addr), 32'h150000);
        finish_access();
    endtask

    task automatic t_upper();
        bank_write(16'hFFC7, 1'b0, 1'b0);
        access(20'hC00FF, 1'b0);
        check("R3 upper bits ignored", 32'(flash_addr), 32'h0700FF);
        finish_access();
    endtask

    task automatic t_noload();
        bank_write(16'h0022, 1'b0, 1'b1);
        bank_write(16'h0033, 1'b1, 1'b0);
        access(20'hC0001, 1'b0);
        check("R4 no half load", 32'(flash_addr), 32'h070001);
        finish_access();
    endtask

    task automatic t_main();
        access(20'hCFFFF, 1'b0);
        check("R5 main top", 32'(flash_addr), 32'h07FFFF);
        check("R5 hit_main", 32'(hit_main), 32'h1);
        check("R10 excl main", 32'(hit_xover), 32'h0);
        finish_access();
    endtask

    task automatic t_xover();
        access(20'hD07FF, 1'b0);
        check("R6 xover top", 32'(flash_addr), 32'h0807FF);
        check("R6 hit_xover", 32'(hit_xover), 32'h1);
        check("R10 excl xover", 32'(hit_main), 32'h0);
        finish_access();
        access(20'hD0123, 1'b0);
        check("R6 xover mid", 32'(flash_addr), 32'h080123);
        finish_access();
    endtask

    task automatic t_wrap();
        bank_write(16'h003F, 1'b0, 1'b0);
        access(20'hD0010, 1'b0);
        check("R7 wrap to bank 0", 32'(flash_addr), 32'h000010);
        finish_access();
        access(20'hCABCD, 1'b0);
        check("R7 main at bank 63", 32'(flash_addr), 32'h3FABCD);
        finish_access();
    endtask

    task automatic t_cs();
        access(20'hD0800, 1'b0);
        check("R8 cs_n above xover", 32'(flash_cs_n), 32'h1);
        check("R8 no hit above xover", 32'({hit_main, hit_xover}), 32'h0);
        finish_access();
        access(20'hBFFFF, 1'b0);
        check("R8 cs_n below main", 32'(flash_cs_n), 32'h1);
        finish_access();
        access(20'hC0000, 1'b1);
        check("R8 cs_n no strobe", 32'(flash_cs_n), 32'h1);
        finish_access();
    endtask

    task automatic t_hold();
        access(20'hC4321, 1'b0);
        check("R9 mapped before hold", 32'(flash_addr), 32'h3F4321);
        finish_access();
        access(20'hE0000, 1'b0);
        check("R9 hold outside", 32'(flash_addr), 32'h3F4321);
        finish_access();
        access(20'hC0055, 1'b1);
        check("R9 hold no strobe", 32'(flash_addr), 32'h3F4321);
        finish_access();
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main_seq
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_upper();
        t_noload();
        t_main();
        t_xover();
        t_wrap();
        t_cs();
        t_hold();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule